// File: doc/BRIEF.md
# Tick-Driven Clock and Pulse Generator

This block produces a single waveform output whose edges are timed in ticks rather than in clock cycles. A tick-enable input marks the cycles in which time moves forward by one unit. Every change of the output happens on the clock edge of a cycle where the tick-enable is high. At no other point can the output move.

Four settings shape the waveform:

- a lead delay before the first transition;
- the number of ticks the output stays high;
- the number of ticks it stays low;
- a flag that chooses whether the output starts low or high.

With these settings the block can act as a free-running clock, as a clock shifted in phase against another instance, or as a one-shot pulse source. A duration set to the sentinel value (all ones, or the largest positive value of the signed field) never ends. The output then parks at its current level for good, and a status pin reports that state.

The settings are sampled only while the synchronous reset is high. Reset also puts the output at its starting level and restarts the waveform. Changing the settings while the block runs has no effect until the next reset. There is no data stream here, so every pin is a plain level signal with no handshake.

Top module: `tick_wavegen`

## Requirements
- R1: While `rst` is high, each clock edge sets `wave_out` to the starting level (0 when `cfg_start_low`=1, 1 when it is 0) and samples the three duration inputs and the start flag.
- R2: `wave_out` and `parked` change only on a clock edge where `tick_en` is 1 and `rst` is 0. A cycle with `tick_en`=0 leaves both unchanged.
- R3: After reset the output holds its starting level for `cfg_first` ticks, then inverts on the tick that completes that count.
- R4: After the lead phase the output alternates: it stays high for `cfg_high` ticks and low for `cfg_low` ticks, and the order of the phases follows from the level reached.
- R5: With first=1, high=1, low=1 and start-low, the output is 0 after reset and inverts on every tick.
- R6: A duration equal to all ones (-1) or to 2^(W-1)-1 is infinite. Once that phase is entered, `wave_out` never changes again and `parked` reads 1 until the next reset. A single pulse results from a finite high phase followed by an infinite low phase.
- R7: A duration that is zero or negative (other than -1) is treated as one tick.
- R8: Changes to `cfg_first`, `cfg_high`, `cfg_low` or `cfg_start_low` while `rst` is 0 have no effect on the waveform.
- R9: With high=2 and low=2, setting first=2 instead of first=1 delays the waveform by exactly one tick, a quarter of its period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset; settings are sampled while high |
| tick_en | input | 1 | Advances time by one tick in each cycle it is high |
| cfg_first | input | W | Lead delay in ticks, signed |
| cfg_high | input | W | High duration in ticks, signed |
| cfg_low | input | W | Low duration in ticks, signed |
| cfg_start_low | input | 1 | 1: start low, 0: start high |
| wave_out | output | 1 | Generated clock or pulse |
| parked | output | 1 | High while the current phase is infinite |

## Verification
The bench builds the block with W=16, so the positive sentinel 32767 can be driven directly next to -1, along with zero and negative durations. A narrow field also keeps the counters small enough that a short run sweeps every phase. Ticks are driven either on every cycle or from a pseudo-random pattern with gaps, which exercises the case where ticks stop while a phase is still counting. Two runs with the same high and low settings but different lead delays are compared to each other one tick apart.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef enum logic [1:0] {
    PH_LEAD = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

  localparam int NUM_DUR = 3;
endpackage

// File: rtl/wg_dur_latch.sv
module wg_dur_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] len,
  output logic         inf
);
  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] MAX_POS  = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] ONE      = W'(1);

  // Settings are captured only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) begin
      inf <= (raw == ALL_ONES) || (raw == MAX_POS);
      len <= ($signed(raw) < $signed(ONE)) ? ONE : raw;
    end
  end
endmodule

// File: rtl/wg_phase_count.sv
module wg_phase_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         hold,
  input  logic [W-1:0] limit,
  output logic         expire
);
  logic [W-1:0] count;
  logic [W-1:0] count_nxt;

  always_comb begin
    count_nxt = count + W'(1);
    expire    = tick && !hold && (count_nxt == limit);
  end

  // An infinite phase freezes the counter, so it can never wrap.
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (tick && !hold) begin
      count <= expire ? '0 : count_nxt;
    end
  end
endmodule

// File: rtl/wg_phase_ctrl.sv
module wg_phase_ctrl
  import wg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_low,
  input  logic         expire,
  input  logic [W-1:0] len_first,
  input  logic [W-1:0] len_high,
  input  logic [W-1:0] len_low,
  input  logic         inf_first,
  input  logic         inf_high,
  input  logic         inf_low,
  output logic         level,
  output logic [W-1:0] cur_len,
  output logic         cur_inf
);
  phase_e phase;

  always_comb begin
    unique case (phase)
      PH_HIGH: begin cur_len = len_high;  cur_inf = inf_high;  end
      PH_LOW:  begin cur_len = len_low;   cur_inf = inf_low;   end
      default: begin cur_len = len_first; cur_inf = inf_first; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_LEAD;
      level <= !start_low;
    end else if (expire) begin
      level <= !level;
      phase <= level ? PH_LOW : PH_HIGH;
    end
  end
endmodule

// File: rtl/tick_wavegen.sv
module tick_wavegen
  import wg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic [W-1:0] cfg_first,
  input  logic [W-1:0] cfg_high,
  input  logic [W-1:0] cfg_low,
  input  logic         cfg_start_low,
  output logic         wave_out,
  output logic         parked
);
  logic [W-1:0] raw_dur [NUM_DUR];
  logic [W-1:0] len_dur [NUM_DUR];
  logic         inf_dur [NUM_DUR];
  logic [W-1:0] cur_len;
  logic         cur_inf;
  logic         expire;

  // Index 0: lead delay, 1: high phase, 2: low phase (matches phase_e).
  assign raw_dur[0] = cfg_first;
  assign raw_dur[1] = cfg_high;
  assign raw_dur[2] = cfg_low;

  for (genvar gi = 0; gi < NUM_DUR; gi++) begin : g_dur
    wg_dur_latch #(.W(W)) u_latch (
      .clk (clk),
      .rst (rst),
      .raw (raw_dur[gi]),
      .len (len_dur[gi]),
      .inf (inf_dur[gi])
    );
  end

  wg_phase_count #(.W(W)) u_count (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_en),
    .hold   (cur_inf),
    .limit  (cur_len),
    .expire (expire)
  );

  wg_phase_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_low (cfg_start_low),
    .expire    (expire),
    .len_first (len_dur[0]),
    .len_high  (len_dur[1]),
    .len_low   (len_dur[2]),
    .inf_first (inf_dur[0]),
    .inf_high  (inf_dur[1]),
    .inf_low   (inf_dur[2]),
    .level     (wave_out),
    .cur_len   (cur_len),
    .cur_inf   (cur_inf)
  );

  assign parked = cur_inf;
endmodule

// File: rtl/tick_wavegen_checks.sv
module tick_wavegen_checks (
  input logic clk,
  input logic rst,
  input logic tick_en,
  input logic cfg_start_low,
  input logic wave_out,
  input logic parked
);
  p_reset_level_r1: assert property (@(posedge clk)
    rst |=> (wave_out == !$past(cfg_start_low)));

  p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(wave_out));

  p_parked_without_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(parked));

  p_parked_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    parked |=> (parked && $stable(wave_out)));
endmodule

bind tick_wavegen tick_wavegen_checks u_checks (
  .clk           (clk),
  .rst           (rst),
  .tick_en       (tick_en),
  .cfg_start_low (cfg_start_low),
  .wave_out      (wave_out),
  .parked        (parked)
);

// File: tb/tb_tick_wavegen.sv
module tb_tick_wavegen;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_en = 1'b0;
  logic [W-1:0] cfg_first = 16'd1;
  logic [W-1:0] cfg_high  = 16'd1;
  logic [W-1:0] cfg_low   = 16'd1;
  logic         cfg_start_low = 1'b1;
  logic         wave_out;
  logic         parked;

  always #2.5 clk = ~clk;

  tick_wavegen #(.W(W)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .cfg_first(cfg_first), .cfg_high(cfg_high), .cfg_low(cfg_low),
    .cfg_start_low(cfg_start_low), .wave_out(wave_out), .parked(parked)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model.
  bit m_started = 0;
  bit m_lvl;
  int m_phase, m_cnt;
  int m_len [3];
  bit m_inf [3];

  function automatic int nlen(logic [W-1:0] v);
    if ($signed(v) < 1) return 1;
    return int'(v);
  endfunction
  function automatic bit ninf(logic [W-1:0] v);
    return (v == 16'hFFFF) || (v == 16'h7FFF);
  endfunction

  always @(posedge clk) begin
    m_started = 1;
    if (rst) begin
      m_len[0] = nlen(cfg_first); m_inf[0] = ninf(cfg_first);
      m_len[1] = nlen(cfg_high);  m_inf[1] = ninf(cfg_high);
      m_len[2] = nlen(cfg_low);   m_inf[2] = ninf(cfg_low);
      m_lvl = !cfg_start_low;
      m_phase = 0;
      m_cnt = 0;
    end else if (tick_en && !m_inf[m_phase]) begin
      m_cnt++;
      if (m_cnt == m_len[m_phase]) begin
        m_cnt = 0;
        m_lvl = !m_lvl;
        m_phase = m_lvl ? 1 : 2;
      end
    end
  end

  always @(negedge clk) begin
    if (m_started) begin
      chk(wave_out == m_lvl, "wave_out", wave_out, m_lvl);
      chk(parked == m_inf[m_phase], "parked", parked, m_inf[m_phase]);
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  int rec = 0;
  int rec_a[$];
  int rec_b[$];

  task automatic do_reset(logic [W-1:0] f, logic [W-1:0] h, logic [W-1:0] l, logic sl);
    @(negedge clk);
    cfg_first = f; cfg_high = h; cfg_low = l; cfg_start_low = sl;
    rst = 1'b1; tick_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(int n, bit gappy);
    for (int i = 0; i < n; i++) begin
      if (rec == 1) rec_a.push_back(int'(wave_out));
      if (rec == 2) rec_b.push_back(int'(wave_out));
      tick_en = gappy ? lfsr[0] : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 and R5: default settings, starts low, one inversion per tick
    tag = "R1";
    do_reset(16'd1, 16'd1, 16'd1, 1'b1);
    chk(wave_out == 1'b0, "reset level low", wave_out, 0);
    tag = "R5";
    run(12, 1'b0);

    // R3, R4, R2: start high, longer phases, ticks with gaps
    tag = "R1";
    do_reset(16'd4, 16'd3, 16'd2, 1'b0);
    chk(wave_out == 1'b1, "reset level high", wave_out, 1);
    tag = "R3";
    run(30, 1'b1);
    tag = "R4";
    run(80, 1'b1);
    tag = "R2";
    run(40, 1'b1);

    // R6: single pulse through an infinite low phase (-1)
    tag = "R6";
    do_reset(16'd1, 16'd2, 16'hFFFF, 1'b1);
    run(40, 1'b0);
    chk(parked == 1'b1, "pulse parked", parked, 1);
    chk(wave_out == 1'b0, "pulse ends low", wave_out, 0);

    // R6: positive sentinel on the high phase
    do_reset(16'd2, 16'h7FFF, 16'd1, 1'b1);
    run(30, 1'b0);
    chk(parked == 1'b1, "high parked", parked, 1);
    chk(wave_out == 1'b1, "held high", wave_out, 1);

    // R7: zero and negative durations act as one tick
    tag = "R7";
    do_reset(16'd0, 16'd0, 16'hFFFB, 1'b1);
    run(20, 1'b0);
    do_reset(16'h8000, 16'hFFFE, 16'd0, 1'b0);
    run(20, 1'b1);

    // R8: settings changed mid-run are ignored
    tag = "R8";
    do_reset(16'd1, 16'd2, 16'd2, 1'b1);
    run(5, 1'b0);
    cfg_high = 16'd7; cfg_low = 16'hFFFF; cfg_first = 16'd9; cfg_start_low = 1'b0;
    run(30, 1'b0);
    chk(parked == 1'b0, "not parked after live change", parked, 0);

    // R9: lead delay of 2 shifts a 2/2 clock by one tick
    tag = "R9";
    do_reset(16'd1, 16'd2, 16'd2, 1'b1);
    rec = 1; run(16, 1'b0); rec = 0;
    do_reset(16'd2, 16'd2, 16'd2, 1'b1);
    rec = 2; run(16, 1'b0); rec = 0;
    for (int t = 1; t < 16; t++)
      chk(rec_b[t] == rec_a[t-1], "shifted sample", rec_b[t], rec_a[t-1]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule